// File: doc/BRIEF.md
# Byte-Wide Three-Port Parallel I/O Controller

This block gives a host three 8-bit general-purpose ports, called A, B and C, through a single byte-wide register window. A 2-bit offset selects one of the three port data registers or the control register. The host writes a control byte that either sets the port directions or changes one bit of port C. Port C is split into an upper and a lower nibble, and each nibble has its own direction. Each port or nibble drives an output-enable, so external bidirectional transceivers follow the programmed direction.

Only plain unhandshaked transfers are supported. The mode fields of the control byte are stored and read back, but they have no effect on port behaviour. Reads are combinational on the offset. A port set as input returns the live pin levels, and a port set as output returns its output latch. The output latches always drive the `*_out` pins, and the output-enables decide whether the transceivers pass those values to the outside.

Top module: `pio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, `pa_out`, `pb_out` and `pc_out` are all ones and every output-enable is 0. After reset, a control read returns 0x9B, and every port reads its pins.
- R2: The offsets are 0 for port A data, 1 for port B data, 2 for port C data and 3 for the control byte. A data write takes effect at the next clock edge.
- R3: A control write with bit 7 = 1 sets the directions. Bit 4 sets port A, bit 3 sets the upper nibble of C, bit 1 sets port B and bit 0 sets the lower nibble of C. A value of 1 means input (output-enable 0), and 0 means output (output-enable 1).
- R4: Every control write with bit 7 = 1 clears all three output latches to 0.
- R5: A control read returns bit 7 = 1 and, in bits 6:0, the bits 6:0 of the last direction-setting write. Bits 6:5 and bit 2 are the mode fields, which are stored only.
- R6: A control write with bit 7 = 0 writes bit 0 into port C bit n, where n is the value of bits 3:1. No other latch bit changes, and the control byte does not change.
- R7: Reading port A or port B returns the pins when the port is an input, and the latch when it is an output.
- R8: A port C read builds each nibble on its own. A nibble set as input returns its pins, and a nibble set as output returns its latch.
- R9: Data writes and port C bit writes update the latch even when the target is an input. The new value shows on the `*_out` pins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pc_in | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A drive value |
| pb_out | output | 8 | Port B drive value |
| pc_out | output | 8 | Port C drive value |
| pa_oe | output | 1 | Port A output-enable |
| pb_oe | output | 1 | Port B output-enable |
| pcu_oe | output | 1 | Port C bits 7:4 output-enable |
| pcl_oe | output | 1 | Port C bits 3:0 output-enable |

## Verification
The bench drives random direction settings while the pins change, so that port C reads combine pins and latch in every nibble pairing. A design that used one direction bit for the whole of port C would return the wrong nibble. Port C bit writes go to nibbles that are inputs and use all eight bit indices. An off-by-one in the index decode, or a bit write that is dropped while the nibble is an input, shows up on `pc_out`. Direction-setting writes are sent after the latches hold nonzero data, to catch a design that fails to clear them. A design that returns the raw stored byte for a control read, or that loses the mode fields, fails the control readback check.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        PIO_OFS_A   = 2'd0,
        PIO_OFS_B   = 2'd1,
        PIO_OFS_C   = 2'd2,
        PIO_OFS_CTL = 2'd3
    } pio_ofs_e;

    // Stored control fields; 1 in a dir field means input
    typedef struct packed {
        logic [1:0] mode_hi;
        logic       dir_a;
        logic       dir_cu;
        logic       mode_lo;
        logic       dir_b;
        logic       dir_cl;
    } pio_ctl_t;

    localparam pio_ctl_t PIO_CTL_RESET = '{
        mode_hi: 2'b00, dir_a: 1'b1, dir_cu: 1'b1,
        mode_lo: 1'b0,  dir_b: 1'b1, dir_cl: 1'b1
    };

endpackage

// File: rtl/pio_ctl_reg.sv
module pio_ctl_reg
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    output pio_ctl_t   ctl_q,
    output logic       mode_wr,
    output logic       bit_wr,
    output logic [2:0] bit_idx,
    output logic       bit_val
);

    typedef struct packed {
        pio_ctl_t ctl;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        mode_wr = ctl_wr &&  ctl_data[7];
        bit_wr  = ctl_wr && !ctl_data[7];
        bit_idx = ctl_data[3:1];
        bit_val = ctl_data[0];
        st_d    = st_q;
        if (mode_wr) begin
            st_d.ctl = pio_ctl_t'(ctl_data[6:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= PIO_CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q = st_q.ctl;

    AST_BITOP_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        bit_wr |=> $stable(ctl_q)); // R6

endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_wr,
    input  logic [W-1:0]     byte_data,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     lat_q
);

    logic [W-1:0] lat_d;

    always_comb begin
        lat_d = lat_q;
        if (clr) begin
            lat_d = '0;
        end else if (byte_wr) begin
            lat_d = byte_data;
        end else if (bit_wr) begin
            lat_d[bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat_q == '0)); // R4

    AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && !clr && !byte_wr) |=> ($countones(lat_q ^ $past(lat_q)) <= 1)); // R6

endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
    import pio_pkg::*;
#(
    parameter int W = 8,
    localparam int NIB_W = W / 2
) (
    input  logic [1:0]   addr,
    input  pio_ctl_t     ctl,
    input  logic [W-1:0] a_lat,
    input  logic [W-1:0] b_lat,
    input  logic [W-1:0] c_lat,
    input  logic [W-1:0] a_pin,
    input  logic [W-1:0] b_pin,
    input  logic [W-1:0] c_pin,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] c_view;
    logic [1:0]   c_dir;

    assign c_dir = {ctl.dir_cu, ctl.dir_cl};

    for (genvar n = 0; n < 2; n++) begin : g_nib
        assign c_view[n*NIB_W +: NIB_W] = c_dir[n] ? c_pin[n*NIB_W +: NIB_W]
                                                   : c_lat[n*NIB_W +: NIB_W];
    end

    always_comb begin
        case (pio_ofs_e'(addr))
            PIO_OFS_A:   rd_data = ctl.dir_a ? a_pin : a_lat;
            PIO_OFS_B:   rd_data = ctl.dir_b ? b_pin : b_lat;
            PIO_OFS_C:   rd_data = c_view;
            default:     rd_data = W'({1'b1, ctl});
        endcase
    end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pa_in,
    input  logic [DATA_W-1:0] pb_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pc_out,
    output logic              pa_oe,
    output logic              pb_oe,
    output logic              pcu_oe,
    output logic              pcl_oe
);

    pio_ctl_t          ctl_q;
    logic              mode_wr, bit_wr, bit_val;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] a_lat, b_lat, c_lat;
    logic              wr_a, wr_b, wr_c, wr_ctl;

    always_comb begin
        wr_a   = wr_en && (addr == PIO_OFS_A);
        wr_b   = wr_en && (addr == PIO_OFS_B);
        wr_c   = wr_en && (addr == PIO_OFS_C);
        wr_ctl = wr_en && (addr == PIO_OFS_CTL);
    end

    pio_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_ctl),
        .ctl_data (wr_data[7:0]),
        .ctl_q    (ctl_q),
        .mode_wr  (mode_wr),
        .bit_wr   (bit_wr),
        .bit_idx  (bit_idx),
        .bit_val  (bit_val)
    );

    pio_out_latch #(.W(DATA_W)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr), .byte_wr(wr_a), .byte_data(wr_data),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .lat_q(a_lat)
    );

    pio_out_latch #(.W(DATA_W)) u_lat_b (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr), .byte_wr(wr_b), .byte_data(wr_data),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .lat_q(b_lat)
    );

    pio_out_latch #(.W(DATA_W)) u_lat_c (
        .clk(clk), .rst_n(rst_n), .clr(mode_wr), .byte_wr(wr_c), .byte_data(wr_data),
        .bit_wr(bit_wr), .bit_idx(IDX_W'(bit_idx)), .bit_val(bit_val), .lat_q(c_lat)
    );

    pio_read_mux #(.W(DATA_W)) u_rd (
        .addr   (addr),
        .ctl    (ctl_q),
        .a_lat  (a_lat),
        .b_lat  (b_lat),
        .c_lat  (c_lat),
        .a_pin  (pa_in),
        .b_pin  (pb_in),
        .c_pin  (pc_in),
        .rd_data(rd_data)
    );

    always_comb begin
        pa_out = rst_n ? a_lat : '1;
        pb_out = rst_n ? b_lat : '1;
        pc_out = rst_n ? c_lat : '1;
        pa_oe  = rst_n && !ctl_q.dir_a;
        pb_oe  = rst_n && !ctl_q.dir_b;
        pcu_oe = rst_n && !ctl_q.dir_cu;
        pcl_oe = rst_n && !ctl_q.dir_cl;
    end

    AST_CTL_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == PIO_OFS_CTL) |-> rd_data[7]); // R5

    AST_PORTA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (pa_out == $past(wr_data))); // R2

    AST_MODE_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_data[7]) |=> (pa_oe == !$past(wr_data[4]))); // R3

endmodule

// File: tb/pio_port_ctrl_tb.sv
module pio_port_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe, pcu_oe, pcl_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] m_ctl;
    logic [7:0] m_a, m_b, m_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
        .pa_oe(pa_oe), .pb_oe(pb_oe), .pcu_oe(pcu_oe), .pcl_oe(pcl_oe)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // model: direction bits of m_ctl: [4]=A [3]=C hi [1]=B [0]=C lo, 1 = input
    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_ctl[4] ? pa_in : m_a;
            2'd1: return m_ctl[1] ? pb_in : m_b;
            2'd2: return {m_ctl[3] ? pc_in[7:4] : m_c[7:4], m_ctl[0] ? pc_in[3:0] : m_c[3:0]};
            default: return {1'b1, m_ctl};
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_a = d;
            2'd1: m_b = d;
            2'd2: m_c = d;
            default: begin
                if (d[7]) begin
                    m_ctl = d[6:0]; m_a = 0; m_b = 0; m_c = 0;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #1;
            check(a == 3 ? "R5 ctl read" : (a == 2 ? "R8 portC read" : "R7 port read"),
                  rd_data, exp_rd(2'(a)));
        end
        check("R9 pa_out", pa_out, m_a);
        check("R9 pb_out", pb_out, m_b);
        check("R6 pc_out", pc_out, m_c);
        check("R3 oe", {4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe},
              {4'b0, ~m_ctl[4], ~m_ctl[1], ~m_ctl[3], ~m_ctl[0]});
        if (tag.len() == 0) checks = checks;
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_ctl = 7'h1B; m_a = 0; m_b = 0; m_c = 0;
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        // R1: during reset
        #(CLK_PERIOD*2 + 1);
        check("R1 pa_out in reset", pa_out, 8'hFF);
        check("R1 pb_out in reset", pb_out, 8'hFF);
        check("R1 pc_out in reset", pc_out, 8'hFF);
        check("R1 oe in reset", {4'b0, pa_oe, pb_oe, pcu_oe, pcl_oe}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        addr = 2'd3; #1;
        check("R1 ctl after reset", rd_data, 8'h9B);
        check_all("R1");

        // R9: data write to input port reaches pa_out, read still pins
        wr(2'd0, 8'hA5);
        check_all("R9");
        // R8: mixed nibble directions: upper output, lower input
        wr(2'd3, 8'h81);
        check_all("R4 R8");
        wr(2'd2, 8'h3C);
        check_all("R8");
        // R6: bit writes to every index, including the input nibble
        for (int i = 0; i < 8; i++) begin
            wr(2'd3, {4'b0, 3'(i), 1'b1});
            check_all("R6 set");
        end
        wr(2'd3, 8'h0C);
        check_all("R6 clear");
        // R4: latches nonzero, then direction write clears them; mode bits kept (R5)
        wr(2'd0, 8'hFF); wr(2'd1, 8'h77);
        wr(2'd3, 8'hE4);
        check_all("R4 R5");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            wr(a, d);
            check_all("rand");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule